// File: doc/BRIEF.md
# Target Bus Status Arbiter

This block sits on the target side of a graphics port and decides, once per clock, what the attached master does next on the shared address/data bus. It looks at six request sources: high- and low-priority read returns waiting to go back to the master, high- and low-priority write-data phases the target is ready to accept, a bus request from the master, and a pending fast-write push from the target. It also looks at two buffer-full flags from the master. It then issues an active-low grant together with a 3-bit status code, or it starts a fast write with the grant left deasserted.

The status code has meaning only while the grant is low. Low-priority read returns are held off while the master reports that its read buffer is full. Fast writes are held off while the master reports that its write buffer is full. A master that does not implement these flags leaves them pulled high, and then no gating takes place.

The decision is a registered state, `state_q`. It takes one of seven named states: `S_IDLE`, `S_HP_RD`, `S_HP_WR`, `S_LP_RD`, `S_LP_WR`, `S_MST` and `S_FW`. On every rising edge the state moves to the highest-priority eligible source, or to `S_IDLE` when no source is eligible. Any state can move to any other state in one edge. Each state therefore lasts exactly one clock per decision, and a source that stays pending is granted again on the next edge.

Top module: `arb_status_top`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `gnt_n` is 1, `fw_start` is 0 and `st_code` is 3'b111.
- R2: When granted (`gnt_n`=0), `st_code` is one of five values: 3'b001 for a high-priority read return, 3'b011 for a high-priority write-data request, 3'b000 for a low-priority read return, 3'b010 for a low-priority write-data request, or 3'b111 for permission to start a master transaction.
- R3: `st_code` never takes the values 3'b100, 3'b101 or 3'b110.
- R4: When several sources are eligible, the winner is chosen in this order: high-priority read, high-priority write, low-priority read, low-priority write, master request, fast write.
- R5: The outputs are registered. They reflect the inputs sampled at the previous rising edge and stay stable between edges.
- R6: While `rd_full_n` is 0 at an edge, no low-priority read return is granted at that edge, and the next eligible source wins instead.
- R7: While `wr_full_n` is 0 at an edge, `fw_start` is not asserted at that edge, and no other output is produced for the fast write.
- R8: A fast-write decision drives `fw_start` to 1 with `gnt_n` held at 1, for one clock.
- R9: With no eligible source, the block goes idle: `gnt_n` is 1 and `fw_start` is 0.
- R10: With both buffer-full inputs held high, the low-priority read return and the fast write are eligible whenever they are pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_rd_pend | input | 1 | A high-priority read return is waiting |
| hp_wr_pend | input | 1 | A high-priority write-data phase is wanted |
| lp_rd_pend | input | 1 | A low-priority read return is waiting |
| lp_wr_pend | input | 1 | A low-priority write-data phase is wanted |
| bus_req | input | 1 | The master requests the bus to start a transaction |
| fw_pend | input | 1 | The target has fast-write data to push |
| rd_full_n | input | 1 | Master read buffer full, active low |
| wr_full_n | input | 1 | Master fast-write buffer full, active low |
| gnt_n | output | 1 | Grant to the master, active low |
| st_code | output | 3 | Status code, valid only while `gnt_n` is 0 |
| fw_start | output | 1 | Starts a fast-write transaction, one clock |

## Verification
The assertions assume that every pending flag and buffer-full flag is a level that is sampled at the rising edge. They also assume that the inputs are known (not X) from the first edge after reset. The stimulus meets these assumptions by changing inputs only at falling edges, and it never leaves an input undriven. Each vector is held across exactly one rising edge, and the outputs are then read at the following falling edge.

// File: rtl/arb_status_pkg.sv
package arb_status_pkg;

    // Source indices. A lower index means a higher priority.
    localparam int SRC_HP_RD = 0;
    localparam int SRC_HP_WR = 1;
    localparam int SRC_LP_RD = 2;
    localparam int SRC_LP_WR = 3;
    localparam int SRC_MST   = 4;
    localparam int SRC_FW    = 5;
    localparam int N_SRC     = 6;

    // Status code values as seen by the master.
    typedef enum logic [2:0] {
        CODE_LP_RD  = 3'b000,
        CODE_HP_RD  = 3'b001,
        CODE_LP_WR  = 3'b010,
        CODE_HP_WR  = 3'b011,
        CODE_START  = 3'b111
    } st_code_e;

    // Decision states of the arbiter.
    typedef enum logic [2:0] {
        S_IDLE,
        S_HP_RD,
        S_HP_WR,
        S_LP_RD,
        S_LP_WR,
        S_MST,
        S_FW
    } arb_state_e;

endpackage

// File: rtl/arb_req_qual.sv
module arb_req_qual
    import arb_status_pkg::*;
(
    input  logic [N_SRC-1:0] pend,
    input  logic             rd_full_n,
    input  logic             wr_full_n,
    output logic [N_SRC-1:0] elig
);

    // Every source passes through unchanged, except the low-priority read
    // return and the fast write. Those two are held back while the master
    // reports the matching buffer as full.
    always_comb begin
        elig            = pend;
        elig[SRC_LP_RD] = pend[SRC_LP_RD] & rd_full_n;
        elig[SRC_FW]    = pend[SRC_FW]    & wr_full_n;
    end

endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
    parameter int N = 6
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] win,
    output logic         any
);

    // Fixed priority: bit 0 is the highest.
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_pick
            if (i == 0) begin : g_top
                assign win[i] = req[i];
            end else begin : g_rest
                assign win[i] = req[i] & ~(|req[i-1:0]);
            end
        end
    endgenerate

    assign any = |req;

endmodule

// File: rtl/arb_out_enc.sv
module arb_out_enc
    import arb_status_pkg::*;
(
    input  arb_state_e  state,
    output logic        gnt_n,
    output logic [2:0]  st_code,
    output logic        fw_start
);

    always_comb begin
        gnt_n    = 1'b1;
        st_code  = CODE_START;
        fw_start = 1'b0;
        unique case (state)
            S_IDLE:  begin end
            S_HP_RD: begin gnt_n = 1'b0; st_code = CODE_HP_RD; end
            S_HP_WR: begin gnt_n = 1'b0; st_code = CODE_HP_WR; end
            S_LP_RD: begin gnt_n = 1'b0; st_code = CODE_LP_RD; end
            S_LP_WR: begin gnt_n = 1'b0; st_code = CODE_LP_WR; end
            S_MST:   begin gnt_n = 1'b0; st_code = CODE_START; end
            S_FW:    begin fw_start = 1'b1; end
            default: begin end
        endcase
    end

endmodule

// File: rtl/arb_status_top.sv
module arb_status_top
    import arb_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hp_rd_pend,
    input  logic       hp_wr_pend,
    input  logic       lp_rd_pend,
    input  logic       lp_wr_pend,
    input  logic       bus_req,
    input  logic       fw_pend,
    input  logic       rd_full_n,
    input  logic       wr_full_n,
    output logic       gnt_n,
    output logic [2:0] st_code,
    output logic       fw_start
);

    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] elig;
    logic [N_SRC-1:0] win;
    logic             any_elig;
    arb_state_e       state_q;
    arb_state_e       state_d;

    assign pend[SRC_HP_RD] = hp_rd_pend;
    assign pend[SRC_HP_WR] = hp_wr_pend;
    assign pend[SRC_LP_RD] = lp_rd_pend;
    assign pend[SRC_LP_WR] = lp_wr_pend;
    assign pend[SRC_MST]   = bus_req;
    assign pend[SRC_FW]    = fw_pend;

    arb_req_qual u_qual (
        .pend      (pend),
        .rd_full_n (rd_full_n),
        .wr_full_n (wr_full_n),
        .elig      (elig)
    );

    arb_prio_pick #(.N(N_SRC)) u_pick (
        .req (elig),
        .win (win),
        .any (any_elig)
    );

    // Next decision, taken from the one-hot winner.
    always_comb begin
        state_d = S_IDLE;
        if (any_elig) begin
            unique case (1'b1)
                win[SRC_HP_RD]: state_d = S_HP_RD;
                win[SRC_HP_WR]: state_d = S_HP_WR;
                win[SRC_LP_RD]: state_d = S_LP_RD;
                win[SRC_LP_WR]: state_d = S_LP_WR;
                win[SRC_MST]:   state_d = S_MST;
                win[SRC_FW]:    state_d = S_FW;
                default:        state_d = S_IDLE;
            endcase
        end
    end

    // State register: one decision per clock.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    arb_out_enc u_enc (
        .state    (state_q),
        .gnt_n    (gnt_n),
        .st_code  (st_code),
        .fw_start (fw_start)
    );

endmodule

// File: rtl/arb_status_chk.sv
module arb_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hp_rd_pend,
    input logic       hp_wr_pend,
    input logic       lp_rd_pend,
    input logic       lp_wr_pend,
    input logic       bus_req,
    input logic       fw_pend,
    input logic       rd_full_n,
    input logic       wr_full_n,
    input logic       gnt_n,
    input logic [2:0] st_code,
    input logic       fw_start
);

    // R3: the three reserved codes never appear
    p_no_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_code != 3'b100) && (st_code != 3'b101) && (st_code != 3'b110));

    // R4: a pending high-priority read always wins the next decision
    p_hp_rd_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hp_rd_pend)) |-> (!gnt_n && st_code == 3'b001));

    // R6: with the read buffer full, no low-priority read return is granted
    p_lp_rd_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rd_full_n)) |-> !(!gnt_n && st_code == 3'b000));

    // R7: with the write buffer full, no fast write starts
    p_fw_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_full_n)) |-> !fw_start);

    // R8: a fast write never comes together with a grant
    p_fw_no_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fw_start |-> gnt_n);

    // R9: with nothing pending, the block goes idle
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(hp_rd_pend | hp_wr_pend | lp_rd_pend |
                                 lp_wr_pend | bus_req | fw_pend))
        |-> (gnt_n && !fw_start));

endmodule

bind arb_status_top arb_status_chk u_chk (.*);

// File: tb/arb_status_top_tb.sv
module arb_status_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hp_rd_pend = 1'b0, hp_wr_pend = 1'b0;
    logic       lp_rd_pend = 1'b0, lp_wr_pend = 1'b0;
    logic       bus_req = 1'b0, fw_pend = 1'b0;
    logic       rd_full_n = 1'b1, wr_full_n = 1'b1;
    logic       gnt_n;
    logic [2:0] st_code;
    logic       fw_start;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;  // 125 MHz

    arb_status_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .hp_rd_pend(hp_rd_pend), .hp_wr_pend(hp_wr_pend),
        .lp_rd_pend(lp_rd_pend), .lp_wr_pend(lp_wr_pend),
        .bus_req(bus_req), .fw_pend(fw_pend),
        .rd_full_n(rd_full_n), .wr_full_n(wr_full_n),
        .gnt_n(gnt_n), .st_code(st_code), .fw_start(fw_start)
    );

    // Pending bits, in the order {fw, mst, lp_wr, lp_rd, hp_wr, hp_rd}.
    task automatic drive(input logic [5:0] p, input logic rf_n, input logic wf_n);
        hp_rd_pend = p[0]; hp_wr_pend = p[1]; lp_rd_pend = p[2];
        lp_wr_pend = p[3]; bus_req    = p[4]; fw_pend    = p[5];
        rd_full_n  = rf_n; wr_full_n  = wf_n;
    endtask

    task automatic check(input string tag, input logic eg, input logic [2:0] es,
                         input logic ef);
        n_chk++;
        if (gnt_n !== eg || fw_start !== ef || (!eg && st_code !== es) ||
            st_code === 3'b100 || st_code === 3'b101 || st_code === 3'b110) begin
            n_bad++;
            $display("FAIL %s: got gnt_n=%b st=%b fw=%b, want gnt_n=%b st=%b fw=%b",
                     tag, gnt_n, st_code, fw_start, eg, es, ef);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, sample at the next falling edge.
    task automatic step(input logic [5:0] p, input logic rf_n, input logic wf_n,
                        input string tag, input logic eg, input logic [2:0] es,
                        input logic ef);
        drive(p, rf_n, wf_n);
        @(negedge clk);
        check(tag, eg, es, ef);
    endtask

    task automatic t_reset;
        // Checked while reset is still held.
        check("R1 in reset", 1'b1, 3'b111, 1'b0);
        if (st_code !== 3'b111) begin
            n_bad++; $display("FAIL R1 st: got %b want 111", st_code);
        end
        n_chk++;
        drive(6'b111111, 1'b1, 1'b1);
        rst_n = 1'b1;
        #1;
        check("R1 after release, before edge", 1'b1, 3'b111, 1'b0);
        step(6'b000000, 1'b1, 1'b1, "R1 first cycle with nothing pending", 1'b1, 3'b111, 1'b0);
    endtask

    task automatic t_codes;
        step(6'b000001, 1, 1, "R2 hp read",   1'b0, 3'b001, 1'b0);
        step(6'b000010, 1, 1, "R2 hp write",  1'b0, 3'b011, 1'b0);
        step(6'b000100, 1, 1, "R2 lp read",   1'b0, 3'b000, 1'b0);
        step(6'b001000, 1, 1, "R2 lp write",  1'b0, 3'b010, 1'b0);
        step(6'b010000, 1, 1, "R2 master",    1'b0, 3'b111, 1'b0);
        step(6'b100000, 1, 1, "R8 fast write", 1'b1, 3'b111, 1'b1);
    endtask

    task automatic t_priority;
        step(6'b111111, 1, 1, "R4 all -> hp read",     1'b0, 3'b001, 1'b0);
        step(6'b111110, 1, 1, "R4 hp wr beats rest",   1'b0, 3'b011, 1'b0);
        step(6'b111100, 1, 1, "R4 lp rd beats rest",   1'b0, 3'b000, 1'b0);
        step(6'b111000, 1, 1, "R4 lp wr beats mst/fw", 1'b0, 3'b010, 1'b0);
        step(6'b110000, 1, 1, "R4 mst beats fw",       1'b0, 3'b111, 1'b0);
        step(6'b101010, 1, 1, "R4 hp wr beats lp wr",  1'b0, 3'b011, 1'b0);
    endtask

    task automatic t_gating;
        step(6'b000100, 0, 1, "R6 lp rd blocked alone", 1'b1, 3'b111, 1'b0);
        step(6'b001100, 0, 1, "R6 lp wr wins over blocked lp rd", 1'b0, 3'b010, 1'b0);
        step(6'b110100, 0, 1, "R6 mst wins over blocked lp rd", 1'b0, 3'b111, 1'b0);
        step(6'b100000, 1, 0, "R7 fw blocked", 1'b1, 3'b111, 1'b0);
        step(6'b100100, 0, 0, "R7 both blocked", 1'b1, 3'b111, 1'b0);
        step(6'b100100, 1, 1, "R10 unblocked lp rd", 1'b0, 3'b000, 1'b0);
        step(6'b100000, 1, 1, "R10 unblocked fw", 1'b1, 3'b111, 1'b1);
        step(6'b000001, 0, 0, "R6 hp read unaffected", 1'b0, 3'b001, 1'b0);
    endtask

    task automatic t_timing;
        step(6'b000000, 1, 1, "R9 idle", 1'b1, 3'b111, 1'b0);
        drive(6'b000010, 1, 1);
        #1;
        check("R5 no change before edge", 1'b1, 3'b111, 1'b0);
        @(negedge clk);
        check("R5 grant after edge", 1'b0, 3'b011, 1'b0);
        drive(6'b000000, 1, 1);
        #1;
        check("R5 held until edge", 1'b0, 3'b011, 1'b0);
        @(negedge clk);
        check("R9 back to idle", 1'b1, 3'b111, 1'b0);
        step(6'b100000, 1, 1, "R8 fw one clock", 1'b1, 3'b111, 1'b1);
        step(6'b000000, 1, 1, "R8 fw ends", 1'b1, 3'b111, 1'b0);
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: run hung, got no finish, want finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        t_codes;
        t_priority;
        t_gating;
        t_timing;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule